// File: doc/BRIEF.md
# Triplexed LCD Multiplex Driver

This block produces the drive-level selections for a liquid crystal display that shares each segment line among three backplanes. It runs directly from the oscillator clock. A frame lasts a fixed number of clock cycles, 1200 by default. The frame is cut into three equal time slots, one per backplane. In its own slot a backplane is driven to a full rail, and outside that slot it sits at an intermediate level. Each output is a 2-bit code naming one of four analog levels, and an external level generator turns the code into a voltage.

Every segment line carries three on/off bits, one for each backplane. In the slot of a given backplane, a lit segment is driven to the rail opposite that backplane, and an unlit segment is driven to an intermediate level. The polarity of every rail and middle level flips from one frame to the next, so no segment sees a net DC voltage. The segment bits are taken only at the frame boundary, so each frame shows one consistent pattern. A square-wave annunciator output runs at the frame rate.

Top module: `lcd_mux_driver`

## Requirements
- R1: While reset is asserted, every backplane and segment output holds code 1 (high-middle) and the annunciator output is low.
- R2: Level codes are 0 = top rail, 1 = high-middle, 2 = low-middle, 3 = display rail. The first clock edge after reset release presents position 0 of frame 0. A frame lasts FRAME_DIV cycles and is split into NUM_BP equal slots. During slot k, backplane k is the selected one. Backplane k uses bits [2k+1:2k] of bpDrive.
- R3: In even frames, the selected backplane is at code 0 and the other backplanes are at code 2. In odd frames, the selected backplane is at code 3 and the others are at code 1. Backplane outputs never depend on the segment bits.
- R4: Polarity alternates on every frame. Frame 0 after reset is even.
- R5: A lit segment line is driven to code 3 in even frames and to code 0 in odd frames.
- R6: An unlit segment line is driven to code 1 in even frames and to code 2 in odd frames.
- R7: Segment line s uses bits [2s+1:2s] of segDrive. During slot k, line s shows input bit segBits[s*NUM_BP + k].
- R8: segBits is captured only at the clock edge that ends the last cycle of a frame, and that value is shown for the whole next frame. A change at any other time has no effect. Frame 0 after reset shows every segment unlit.
- R9: annunOut is high for the first FRAME_DIV/2 positions of each frame and low for the rest.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rstN | input | 1 | Asynchronous active-low reset |
| segBits | input | NUM_SEG*NUM_BP | On/off bit per segment line and backplane |
| bpDrive | output | 2*NUM_BP | Level code per backplane |
| segDrive | output | 2*NUM_SEG | Level code per segment line |
| annunOut | output | 1 | Annunciator square wave at the frame rate |

## Verification
Three things fall on the same clock edge at the end of a frame: the capture of new segment bits, the polarity flip, and the slot wrapping back to backplane 0. The bench sets up this collision on purpose. It places the wanted pattern on segBits only one cycle before the closing edge. It drives garbage both earlier in that frame and in the cycle just after the edge. The scoreboard then requires the new frame to show exactly the queued pattern, at the new polarity, from its very first position. The bench also checks the last position of the old frame, which must still show the old pattern at the old polarity.

// File: rtl/lcd_mux_pkg.sv
package lcd_mux_pkg;

  // Drive level codes handed to the external level generator.
  typedef enum logic [1:0] {
    LVL_TOP   = 2'd0,
    LVL_HIMID = 2'd1,
    LVL_LOMID = 2'd2,
    LVL_DISP  = 2'd3
  } driveLevel_t;

  // Strobes from the control section to the datapath.
  typedef struct packed {
    logic frameEnd;   // last cycle of the current frame
    logic polarity;   // 0 = even frame, 1 = odd frame
    logic firstHalf;  // position lies in the first half of the frame
  } ctlStrobe_t;

endpackage

// File: rtl/lcd_mux_ctrl.sv
module lcd_mux_ctrl
  import lcd_mux_pkg::*;
#(
  parameter int FRAME_DIV = 1200,
  parameter int NUM_BP    = 3,
  localparam int SLOT_W   = (NUM_BP > 1) ? $clog2(NUM_BP) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  output ctlStrobe_t        strobe,
  output logic [SLOT_W-1:0] slotIdx
);

  localparam int SLOT_LEN = FRAME_DIV / NUM_BP;
  localparam int HALF     = FRAME_DIV / 2;
  localparam int CNT_W    = $clog2(FRAME_DIV);
  localparam int SC_W     = (SLOT_LEN > 1) ? $clog2(SLOT_LEN) : 1;

  logic [CNT_W-1:0] frameCnt;
  logic [SC_W-1:0]  slotCnt;
  logic             polarity;
  logic             frameEnd;
  logic             slotEnd;

  assign frameEnd = (frameCnt == CNT_W'(FRAME_DIV - 1));
  assign slotEnd  = (slotCnt == SC_W'(SLOT_LEN - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frameCnt <= '0;
      slotCnt  <= '0;
      slotIdx  <= '0;
      polarity <= 1'b0;
    end else if (frameEnd) begin
      frameCnt <= '0;
      slotCnt  <= '0;
      slotIdx  <= '0;
      polarity <= ~polarity;
    end else begin
      frameCnt <= frameCnt + 1'b1;
      if (slotEnd) begin
        slotCnt <= '0;
        slotIdx <= slotIdx + 1'b1;
      end else begin
        slotCnt <= slotCnt + 1'b1;
      end
    end
  end

  always_comb begin
    strobe.frameEnd  = frameEnd;
    strobe.polarity  = polarity;
    strobe.firstHalf = (frameCnt < CNT_W'(HALF));
  end

endmodule

// File: rtl/lcd_mux_datapath.sv
module lcd_mux_datapath
  import lcd_mux_pkg::*;
#(
  parameter int NUM_BP  = 3,
  parameter int NUM_SEG = 12,
  localparam int SLOT_W = (NUM_BP > 1) ? $clog2(NUM_BP) : 1,
  localparam int BITS_W = NUM_SEG * NUM_BP
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  ctlStrobe_t             strobe,
  input  logic [SLOT_W-1:0]      slotIdx,
  input  logic [BITS_W-1:0]      segBits,
  output logic [2*NUM_BP-1:0]    bpDrive,
  output logic [2*NUM_SEG-1:0]   segDrive,
  output logic                   annunOut
);

  logic [BITS_W-1:0]    frameBits;
  logic [2*NUM_BP-1:0]  bpNext;
  logic [2*NUM_SEG-1:0] segNext;

  // Segment pattern held steady for one whole frame.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) frameBits <= '0;
    else if (strobe.frameEnd) frameBits <= segBits;
  end

  // Backplane level per line: rail in own slot, middle otherwise.
  for (genvar b = 0; b < NUM_BP; b++) begin : g_bp
    logic        isSel;
    driveLevel_t lvl;
    assign isSel = (slotIdx == SLOT_W'(b));
    always_comb begin
      if (isSel) lvl = strobe.polarity ? LVL_DISP : LVL_TOP;
      else       lvl = strobe.polarity ? LVL_HIMID : LVL_LOMID;
    end
    assign bpNext[2*b +: 2] = lvl;
  end

  // Segment level per line: opposite rail when lit, middle when dark.
  for (genvar s = 0; s < NUM_SEG; s++) begin : g_seg
    logic [NUM_BP-1:0] lineBits;
    logic              isLit;
    driveLevel_t       lvl;
    assign lineBits = frameBits[s*NUM_BP +: NUM_BP];
    assign isLit    = lineBits[slotIdx];
    always_comb begin
      if (isLit) lvl = strobe.polarity ? LVL_TOP : LVL_DISP;
      else       lvl = strobe.polarity ? LVL_LOMID : LVL_HIMID;
    end
    assign segNext[2*s +: 2] = lvl;
  end

  // Registered outputs so pad drive never glitches between levels.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bpDrive  <= {NUM_BP{LVL_HIMID}};
      segDrive <= {NUM_SEG{LVL_HIMID}};
      annunOut <= 1'b0;
    end else begin
      bpDrive  <= bpNext;
      segDrive <= segNext;
      annunOut <= strobe.firstHalf;
    end
  end

endmodule

// File: rtl/lcd_mux_driver.sv
module lcd_mux_driver
  import lcd_mux_pkg::*;
#(
  parameter int FRAME_DIV = 1200,
  parameter int NUM_BP    = 3,
  parameter int NUM_SEG   = 12
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [NUM_SEG*NUM_BP-1:0]   segBits,
  output logic [2*NUM_BP-1:0]         bpDrive,
  output logic [2*NUM_SEG-1:0]        segDrive,
  output logic                        annunOut
);

  localparam int SLOT_W = (NUM_BP > 1) ? $clog2(NUM_BP) : 1;

  ctlStrobe_t        strobe;
  logic [SLOT_W-1:0] slotIdx;

  lcd_mux_ctrl #(
    .FRAME_DIV (FRAME_DIV),
    .NUM_BP    (NUM_BP)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .slotIdx (slotIdx)
  );

  lcd_mux_datapath #(
    .NUM_BP  (NUM_BP),
    .NUM_SEG (NUM_SEG)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .slotIdx  (slotIdx),
    .segBits  (segBits),
    .bpDrive  (bpDrive),
    .segDrive (segDrive),
    .annunOut (annunOut)
  );

endmodule

// File: rtl/lcd_mux_checker.sv
module lcd_mux_checker
  import lcd_mux_pkg::*;
#(
  parameter int NUM_BP  = 3,
  parameter int NUM_SEG = 12
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [2*NUM_BP-1:0]  bpDrive,
  input logic [2*NUM_SEG-1:0] segDrive,
  input logic                 annunOut
);

  logic              started;
  logic [NUM_BP-1:0] railMask;
  logic              anyDisp;
  logic              segPairOk;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) started <= 1'b0;
    else       started <= 1'b1;
  end

  always_comb begin
    railMask = '0;
    anyDisp  = 1'b0;
    for (int b = 0; b < NUM_BP; b++) begin
      railMask[b] = (bpDrive[2*b +: 2] == LVL_TOP) || (bpDrive[2*b +: 2] == LVL_DISP);
      if (bpDrive[2*b +: 2] == LVL_DISP) anyDisp = 1'b1;
    end
    segPairOk = 1'b1;
    for (int s = 0; s < NUM_SEG; s++) begin
      if (anyDisp  && ((segDrive[2*s +: 2] == LVL_DISP) || (segDrive[2*s +: 2] == LVL_HIMID)))
        segPairOk = 1'b0;
      if (!anyDisp && ((segDrive[2*s +: 2] == LVL_TOP)  || (segDrive[2*s +: 2] == LVL_LOMID)))
        segPairOk = 1'b0;
    end
  end

  // R3: exactly one backplane sits on a rail at any time
  assert_one_rail_R3: assert property (@(posedge clk) disable iff (!rstN)
    started |-> ($countones(railMask) == 1));

  // R4: the rail side flips at each frame start
  assert_polarity_flip_R4: assert property (@(posedge clk) disable iff (!rstN)
    (started && $past(started) && $rose(annunOut)) |-> (anyDisp != $past(anyDisp)));

  // R4: the rail side holds for the rest of the frame
  assert_polarity_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    (started && $past(started) && !$rose(annunOut)) |-> $stable(anyDisp));

  // R5: segment levels always pair with the opposite side of the backplane rail
  assert_seg_pairing_R5: assert property (@(posedge clk) disable iff (!rstN)
    started |-> segPairOk);

  // R8: inside a slot the segment outputs do not move
  assert_seg_steady_R8: assert property (@(posedge clk) disable iff (!rstN)
    (started && $past(started) && $stable(bpDrive)) |-> $stable(segDrive));

endmodule

bind lcd_mux_driver lcd_mux_checker #(
  .NUM_BP  (NUM_BP),
  .NUM_SEG (NUM_SEG)
) u_lcdMuxChk (
  .clk      (clk),
  .rstN     (rstN),
  .bpDrive  (bpDrive),
  .segDrive (segDrive),
  .annunOut (annunOut)
);

// File: tb/lcd_mux_driver_bench.sv
`timescale 1ns/1ps
module lcd_mux_driver_bench;

  localparam int FD     = 1200;
  localparam int NB     = 3;
  localparam int NS     = 12;
  localparam int SLOTL  = FD / NB;
  localparam int NBITS  = NS * NB;
  localparam int FRAMES = 9;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic [NBITS-1:0] segBits = '1;
  logic [2*NB-1:0]  bpDrive;
  logic [2*NS-1:0]  segDrive;
  logic             annunOut;

  int checks = 0;
  int fails  = 0;
  int edgeN  = 0;
  bit running = 1'b0;
  bit done    = 1'b0;

  logic [NBITS-1:0] expQ[$];
  logic [NBITS-1:0] curPat = '0;

  always #2.5 clk = ~clk;

  lcd_mux_driver #(.FRAME_DIV(FD), .NUM_BP(NB), .NUM_SEG(NS)) u_lcd_mux_driver (
    .clk(clk), .rstN(rstN), .segBits(segBits),
    .bpDrive(bpDrive), .segDrive(segDrive), .annunOut(annunOut));

  always @(posedge clk) if (rstN) edgeN <= edgeN + 1;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h (edge %0d)", tag, act, exp, edgeN);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  // Monitor: one expected pattern popped per frame, every position compared.
  always @(negedge clk) begin
    if (running && rstN && edgeN >= 1) begin
      int p, frame, pos, slot;
      bit pol;
      logic [2*NB-1:0] expBp;
      logic [2*NS-1:0] expSeg;
      p = edgeN - 1;
      frame = p / FD;
      pos = p % FD;
      slot = pos / SLOTL;
      pol = frame[0];
      if (pos == 0 && frame >= 1) begin
        if (expQ.size() == 0) begin
          checks++; fails++;
          $display("FAIL R8 actual=empty-queue expected=pattern (frame %0d)", frame);
        end else curPat = expQ.pop_front();
      end
      for (int b = 0; b < NB; b++) begin
        if (b == slot) expBp[2*b +: 2] = pol ? 2'd3 : 2'd0;
        else           expBp[2*b +: 2] = pol ? 2'd1 : 2'd2;
      end
      for (int s = 0; s < NS; s++) begin
        if (curPat[s*NB + slot]) expSeg[2*s +: 2] = pol ? 2'd0 : 2'd3;
        else                     expSeg[2*s +: 2] = pol ? 2'd2 : 2'd1;
      end
      check("R2/R3/R4 backplanes", 64'(bpDrive), 64'(expBp));
      check("R5/R6/R7/R8 segments", 64'(segDrive), 64'(expSeg));
      check("R9 annunciator", 64'(annunOut), 64'(pos < FD / 2));
    end
  end

  task automatic waitEdge(input int target);
    while (edgeN != target) @(negedge clk);
  endtask

  // Driver: garbage early, wanted pattern one cycle before the boundary, garbage right after.
  task automatic loadFrame(input int f, input logic [NBITS-1:0] pat);
    waitEdge(f * FD - 300);
    segBits = ~pat;
    waitEdge(f * FD - 1);
    segBits = pat;
    expQ.push_back(pat);
    waitEdge(f * FD);
    segBits = ~pat ^ 36'h123456789;
  endtask

  initial begin
    logic [NBITS-1:0] pats [FRAMES-1];
    pats[0] = '1;
    pats[1] = '0;
    pats[2] = 36'h924924924;
    pats[3] = 36'h249249249;
    pats[4] = 36'h5A5A5A5A5;
    pats[5] = 36'h000000001;
    pats[6] = 36'h800000000;
    pats[7] = 36'hC3C3C3C3C;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 backplanes in reset", 64'(bpDrive), 64'({NB{2'd1}}));
    check("R1 segments in reset", 64'(segDrive), 64'({NS{2'd1}}));
    check("R1 annunciator in reset", 64'(annunOut), 64'd0);
    running = 1'b1;
    rstN = 1'b1;   // segBits all ones here: frame 0 must still be blank (R8)
    for (int f = 1; f < FRAMES; f++) loadFrame(f, pats[f-1]);
    waitEdge(FRAMES * FD + 1);
    running = 1'b0;
    finishRun();
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finishRun();
  end

endmodule